// File: doc/BRIEF.md
# Utilization-Driven Operating Point Controller

This block chooses a clock-divider level and a matching supply-voltage code for one processing core. Each stream buffer at the core's edge flags a blocked transfer. `in_blocked` comes from the buffer that feeds the core from the interconnect. `out_blocked` comes from the buffer that carries the core's results back. A stalled input side means the core cannot keep up, so it must run faster. A stalled output side means the core produces more than the interconnect can take, so it may run slower.

A free-running timer divides time into observation windows of `WINDOW` cycles. Two counters tally the blocked events of each side during a window. When the window closes, the decision logic compares both totals against `THRESH` and moves the operating point by at most one level. Both counters then start again from zero.

The operating point has four levels. Level 0 is full speed, level 1 is half, level 2 is a quarter and level 3 is an eighth. The voltage code uses the same index, with 0 as the highest supply. A step therefore changes the two outputs one window apart. On the way up, the voltage rises first. On the way down, the clock slows first. The supply is never too low for the clock in use.

Top module: `opp_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `div_sel` = 0 and `vdd_sel` = 0 (full speed, highest supply). The first window starts on the first rising clock edge with `rst_n` high.
- R2: `div_sel` and `vdd_sel` change only on the clock edge that ends a window, which is every `WINDOW` edges after reset release. They are stable on every other edge.
- R3: In a settled state, if the input-blocked count of a window exceeds `THRESH` and the output-blocked count does not, `vdd_sel` decreases by one at the window end and `div_sel` is held.
- R4: In a settled state, if the output-blocked count exceeds `THRESH` and the input-blocked count does not, `div_sel` increases by one at the window end and `vdd_sel` is held.
- R5: In a settled state, if both counts exceed `THRESH`, or neither does, neither output changes.
- R6: At the end of the window after an R3 step, `div_sel` takes the value of `vdd_sel`, whatever the counts were.
- R7: At the end of the window after an R4 step, `vdd_sel` takes the value of `div_sel`, whatever the counts were.
- R8: The level saturates: a speed-up request at level 0 and a slow-down request at level 3 change nothing.
- R9: Event counts do not carry from one window into the next.
- R10: `vdd_sel` never exceeds `div_sel`, so the supply always meets or exceeds what the current clock needs.
- R11: At any edge, each output moves by at most one, and the two outputs never change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_blocked | input | 1 | Input-side buffer reports a blocked transfer this cycle |
| out_blocked | input | 1 | Output-side buffer reports a blocked transfer this cycle |
| div_sel | output | 2 | Clock divider level: 0 full, 1 half, 2 quarter, 3 eighth |
| vdd_sel | output | 2 | Supply code: 0 highest, 3 lowest |

## Verification
An event on the input of the last window cycle is counted in that window's decision. The new output values are visible right after that window-ending edge, with no extra register delay. The bench therefore drives exactly `WINDOW` cycles of stimulus per window and compares both outputs one half cycle after the last edge. It also samples in the middle of each window to confirm that nothing has moved. The bench sweeps every pair of per-window counts from 0 to 4 against a threshold of 2. It also runs long speed-up and slow-down sequences, so the model has to follow two-window steps, the saturation at both ends, and windows that sit just at the threshold.

// File: rtl/opp_pkg.sv
package opp_pkg;
    localparam int LVL_W   = 2;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [1:0] {
        PH_SETTLED = 2'd0,
        PH_RAISING = 2'd1,
        PH_LOWERING = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e ph;
        level_t div;
        level_t vdd;
    } opp_state_t;
endpackage

// File: rtl/opp_win_timer.sv
module opp_win_timer #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int TMR_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(WINDOW - 1);

    logic [TMR_W-1:0] tmr_d, tmr_q;

    always_comb begin
        win_end = (tmr_q == LAST);
        tmr_d   = win_end ? '0 : tmr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2
    tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= LAST);
endmodule

// File: rtl/opp_evt_cnt.sv
module opp_evt_cnt #(
    parameter int WINDOW = 64,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        total = cnt_q + CNT_W'(evt);
        cnt_d = clr ? '0 : total;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    cnt_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < WINDOW);
endmodule

// File: rtl/opp_level_fsm.sv
module opp_level_fsm
    import opp_pkg::*;
#(
    parameter int THRESH = 16,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end,
    input  logic [CNT_W-1:0] in_tot,
    input  logic [CNT_W-1:0] out_tot,
    output level_t           div_sel,
    output level_t           vdd_sel
);
    localparam logic [CNT_W-1:0] TH = CNT_W'(THRESH);
    localparam level_t TOP = level_t'(LVL_MAX);

    opp_state_t st_d, st_q;
    logic too_slow, too_fast;

    always_comb begin
        too_slow = (in_tot > TH) && !(out_tot > TH);
        too_fast = (out_tot > TH) && !(in_tot > TH);
        st_d = st_q;
        if (win_end) begin
            unique case (st_q.ph)
                PH_RAISING: begin
                    st_d.div = st_q.vdd;
                    st_d.ph  = PH_SETTLED;
                end
                PH_LOWERING: begin
                    st_d.vdd = st_q.div;
                    st_d.ph  = PH_SETTLED;
                end
                default: begin
                    if (too_slow && st_q.div != '0) begin
                        st_d.vdd = st_q.div - 1'b1;
                        st_d.ph  = PH_RAISING;
                    end else if (too_fast && st_q.div != TOP) begin
                        st_d.div = st_q.div + 1'b1;
                        st_d.ph  = PH_LOWERING;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_SETTLED, div: '0, vdd: '0};
        else        st_q <= st_d;
    end

    assign div_sel = st_q.div;
    assign vdd_sel = st_q.vdd;

    // R10
    supply_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vdd <= st_q.div);

    // R2
    hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ($stable(st_q.div) && $stable(st_q.vdd)));

    // R11
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(st_q.div) || $stable(st_q.vdd)));

    // R11
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int'(st_q.div) - int'($past(st_q.div)) <= 1) &&
                  (int'($past(st_q.div)) - int'(st_q.div) <= 1) &&
                  (int'(st_q.vdd) - int'($past(st_q.vdd)) <= 1) &&
                  (int'($past(st_q.vdd)) - int'(st_q.vdd) <= 1)));
endmodule

// File: rtl/opp_ctrl.sv
module opp_ctrl
    import opp_pkg::*;
#(
    parameter int WINDOW = 64,
    parameter int THRESH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_blocked,
    input  logic       out_blocked,
    output logic [1:0] div_sel,
    output logic [1:0] vdd_sel
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    logic             win_end;
    logic [1:0]       evt;
    logic [CNT_W-1:0] tot [2];

    assign evt = {out_blocked, in_blocked};

    opp_win_timer #(.WINDOW(WINDOW)) timer_i (
        .clk(clk), .rst_n(rst_n), .win_end(win_end)
    );

    for (genvar g = 0; g < 2; g++) begin : g_side
        opp_evt_cnt #(.WINDOW(WINDOW), .CNT_W(CNT_W)) cnt_i (
            .clk(clk), .rst_n(rst_n), .evt(evt[g]),
            .clr(win_end), .total(tot[g])
        );
    end

    opp_level_fsm #(.THRESH(THRESH), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .win_end(win_end),
        .in_tot(tot[0]), .out_tot(tot[1]),
        .div_sel(div_sel), .vdd_sel(vdd_sel)
    );
endmodule

// File: tb/opp_ctrl_tb_top.sv
module opp_ctrl_tb_top;
    localparam int W  = 8;
    localparam int TH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_blocked = 1'b0, out_blocked = 1'b0;
    logic [1:0] div_sel, vdd_sel;

    int total = 0, bad = 0;
    int mdiv = 0, mvdd = 0, mph = 0;  // mph: 0 settled, 1 raising, 2 lowering
    bit done = 1'b0;

    always #5 clk = ~clk;

    opp_ctrl #(.WINDOW(W), .THRESH(TH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_blocked(in_blocked),
        .out_blocked(out_blocked), .div_sel(div_sel), .vdd_sel(vdd_sel)
    );

    task automatic chk(string tag, int ed, int ev);
        total++;
        if (int'(div_sel) != ed || int'(vdd_sel) != ev) begin
            bad++;
            $display("FAIL %s: div=%0d vdd=%0d expected div=%0d vdd=%0d",
                     tag, div_sel, vdd_sel, ed, ev);
        end
        total++;
        if (vdd_sel > div_sel) begin
            bad++;
            $display("FAIL R10: vdd=%0d exceeds div=%0d expected vdd<=div",
                     vdd_sel, div_sel);
        end
    endtask

    // One window: a input-blocked events, b output-blocked events.
    task automatic run_win(int a, int b);
        string tag;
        int pd = mdiv, pv = mvdd;
        for (int i = 0; i < W; i++) begin
            in_blocked  = (i < a);
            out_blocked = ((W - 1 - i) < b);
            @(posedge clk);
            @(negedge clk);
            if (i == W / 2) chk("R2", pd, pv);
        end
        in_blocked = 1'b0; out_blocked = 1'b0;
        if (mph == 1) begin mdiv = mvdd; mph = 0; tag = "R6"; end
        else if (mph == 2) begin mvdd = mdiv; mph = 0; tag = "R7"; end
        else if (a > TH && b <= TH) begin
            if (mdiv == 0) tag = "R8";
            else begin mvdd = mdiv - 1; mph = 1; tag = "R3"; end
        end else if (b > TH && a <= TH) begin
            if (mdiv == 3) tag = "R8";
            else begin mdiv = mdiv + 1; mph = 2; tag = "R4"; end
        end else tag = "R5";
        chk(tag, mdiv, mvdd);
        total++;
        if (!((mdiv == pd) || (mvdd == pv))) begin
            bad++;
            $display("FAIL R11: both outputs moved, actual div=%0d vdd=%0d expected one held",
                     div_sel, vdd_sel);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 0, 0);
        rst_n = 1'b1;
        chk("R1", 0, 0);
        // speed-up request at full speed saturates
        run_win(W, 0);
        // slow down to the bottom and beyond
        for (int k = 0; k < 8; k++) run_win(0, 5);
        // threshold split across two windows must not combine
        run_win(TH, 0);
        run_win(TH, 0);
        run_win(0, TH);
        run_win(0, TH);
        // full sweep of count pairs
        for (int a = 0; a <= 4; a++)
            for (int b = 0; b <= 4; b++)
                run_win(a, b);
        // climb to the top and beyond
        for (int k = 0; k < 8; k++) run_win(W, 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual hung expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule